// File: doc/BRIEF.md
# Double-Buffered Scanout Base Address Selector

This block keeps two 64-bit framebuffer base addresses for a single display pipe and chooses which of them drives the scanout engine. Software loads the next frame's base address into the slot that is idle. It then writes a flip request to the control word. The selection toggles at the next vertical blanking strobe, so the scanout engine never sees a change in the middle of a frame.

Each 64-bit address is written as two 32-bit words. The control word reports two things: whether a flip is still waiting, and which slot is in use. No field selects a slot directly. Software returns to the other buffer by issuing another flip. The base address output is a register that loads only on the blanking strobe. It therefore holds one value for a whole frame, even while software rewrites the slot in use.

Top module: `flip_scanout_top`

## Requirements
- R1: After reset, slot 0 is active, no flip is pending, both slot addresses read 0, `scan_base` is 0 and `scan_slot` is 0.
- R2: Register indices are: 0 = control, 1 = slot 0 low word, 2 = slot 0 high word, 3 = slot 1 low word, 4 = slot 1 high word. Each address word reads back the last value written to it. Any other index reads 0, and writes to it are dropped.
- R3: The control word reads with bit 7 = flip pending and bit 11 = active slot. All other bits read 0.
- R4: A control write with bit 7 set marks a flip as pending. `scan_slot` and `scan_base` stay unchanged until a blanking strobe.
- R5: On a cycle where `vblank_start` is high and a flip is pending, or is requested in that same cycle, the active slot toggles and the pending flag clears. From the next cycle, `scan_slot` shows the new slot and `scan_base` shows its full 64-bit address {high, low}.
- R6: Further flip requests made while a flip is already pending merge into it, so the next blanking strobe toggles the slot only once.
- R7: A blanking strobe with no flip pending leaves the active slot unchanged. It reloads `scan_base` from the active slot's current address.
- R8: Between blanking strobes, `scan_base` and `scan_slot` hold their values, even when the active slot's address words are written.
- R9: Control writes cannot force the active slot or cancel a pending flip. Bit 11 is read-only, and writing bit 7 as 0 has no effect.
- R10: A second flip, committed at a later blanking strobe, returns the pipe to the slot used before the first flip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_idx) |
| vblank_start | input | 1 | One-cycle strobe at the start of vertical blanking |
| scan_base | output | 64 | Base address presented to the scanout engine |
| scan_slot | output | 1 | Slot currently feeding the scanout engine |

## Verification
A wrong active-slot bit shows up in several places at once. It appears at bit 11 of the control word as soon as it changes, at `scan_slot`, and at `scan_base` one cycle after the strobe that loaded the wrong slot. A pending flag that sticks or drops shows at bit 7 at once. Its effect on the slot appears only after the next strobe, so every scenario reads the control word both before and after each strobe. A corrupted stored address word remains hidden at `scan_base` until a strobe selects its slot. Read-back of every word catches it earlier.

// File: rtl/flip_pkg.sv
package flip_pkg;
    localparam int SLOT_COUNT = 2;
    localparam int CTRL_IDX   = 0;

    typedef struct packed {
        logic pending;
        logic active;
    } flip_state_t;

    // Register index of one word of one slot's address
    function automatic int word_index(input int slot, input int part, input int parts);
        return 1 + slot * parts + part;
    endfunction
endpackage

// File: rtl/flip_addr_bank.sv
module flip_addr_bank
    import flip_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int REG_W  = 32,
    parameter int IDX_W  = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                we,
    input  logic [IDX_W-1:0]                    idx,
    input  logic [REG_W-1:0]                    wdata,
    output logic [SLOT_COUNT-1:0][ADDR_W-1:0]   base,
    output logic [REG_W-1:0]                    rdata
);
    localparam int PARTS = ADDR_W / REG_W;

    for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
        for (genvar p = 0; p < PARTS; p++) begin : g_part
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(word_index(s, p, PARTS));
            logic [REG_W-1:0] word_q;

            always_ff @(posedge clk) begin
                if (rst)
                    word_q <= '0;
                else if (we && idx == MY_IDX)
                    word_q <= wdata;
            end

            assign base[s][p*REG_W +: REG_W] = word_q;

            // R2: a write to this word is visible on the next cycle
            assert property (@(posedge clk) disable iff (rst)
                (we && idx == MY_IDX) |=> (word_q == $past(wdata)))
                else $error("word_write_chk");
        end
    end

    always_comb begin
        rdata = '0;
        for (int s = 0; s < SLOT_COUNT; s++) begin
            for (int p = 0; p < PARTS; p++) begin
                if (idx == IDX_W'(word_index(s, p, PARTS)))
                    rdata = base[s][p*REG_W +: REG_W];
            end
        end
    end
endmodule

// File: rtl/flip_ctrl.sv
module flip_ctrl
    import flip_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flip_req,
    input  logic vblank,
    output logic active,
    output logic pending,
    output logic active_nxt
);
    flip_state_t st_q, st_d;
    logic commit;

    always_comb begin
        commit        = vblank && (st_q.pending || flip_req);
        st_d.active   = st_q.active ^ commit;
        st_d.pending  = commit ? 1'b0 : (st_q.pending || flip_req);
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign active     = st_q.active;
    assign pending    = st_q.pending;
    assign active_nxt = st_d.active;

    // R5
    // pending is always cleared by a strobe
    assert property (@(posedge clk) disable iff (rst)
        vblank |=> !pending)
        else $error("pend_clear_chk");

    // R7
    // the slot never moves without a strobe
    assert property (@(posedge clk) disable iff (rst)
        !vblank |=> $stable(active))
        else $error("slot_hold_chk");

    // R6
    // a pending flip toggles exactly once at the strobe
    assert property (@(posedge clk) disable iff (rst)
        (pending && vblank) |=> (active != $past(active)))
        else $error("single_toggle_chk");

    // R7
    // a strobe with nothing requested keeps the slot
    assert property (@(posedge clk) disable iff (rst)
        (vblank && !pending && !flip_req) |=> $stable(active))
        else $error("idle_strobe_chk");
endmodule

// File: rtl/flip_out_reg.sv
module flip_out_reg
    import flip_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              vblank,
    input  logic                              sel,
    input  logic [SLOT_COUNT-1:0][ADDR_W-1:0] base,
    output logic [ADDR_W-1:0]                 scan_base
);
    always_ff @(posedge clk) begin
        if (rst)
            scan_base <= '0;
        else if (vblank)
            scan_base <= base[sel];
    end

    // R8
    // output frozen between strobes
    assert property (@(posedge clk) disable iff (rst)
        !vblank |=> $stable(scan_base))
        else $error("base_stable_chk");
endmodule

// File: rtl/flip_scanout_top.sv
module flip_scanout_top
    import flip_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int REG_W      = 32,
    parameter int IDX_W      = 3,
    parameter int FLIP_BIT   = 7,
    parameter int ACTIVE_BIT = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              vblank_start,
    output logic [ADDR_W-1:0] scan_base,
    output logic              scan_slot
);
    logic [SLOT_COUNT-1:0][ADDR_W-1:0] slot_base;
    logic [REG_W-1:0] bank_rdata;
    logic ctrl_sel, flip_req, active, pending, active_nxt;

    assign ctrl_sel = (reg_idx == IDX_W'(CTRL_IDX));
    assign flip_req = reg_we && ctrl_sel && reg_wdata[FLIP_BIT];

    flip_addr_bank #(.ADDR_W(ADDR_W), .REG_W(REG_W), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
        .base(slot_base), .rdata(bank_rdata)
    );

    flip_ctrl u_ctrl (
        .clk(clk), .rst(rst), .flip_req(flip_req), .vblank(vblank_start),
        .active(active), .pending(pending), .active_nxt(active_nxt)
    );

    flip_out_reg #(.ADDR_W(ADDR_W)) u_out (
        .clk(clk), .rst(rst), .vblank(vblank_start), .sel(active_nxt),
        .base(slot_base), .scan_base(scan_base)
    );

    assign scan_slot = active;

    always_comb begin
        if (ctrl_sel) begin
            reg_rdata             = '0;
            reg_rdata[FLIP_BIT]   = pending;
            reg_rdata[ACTIVE_BIT] = active;
        end else begin
            reg_rdata = bank_rdata;
        end
    end

    // R5
    // after a strobe the output matches the slot now in use
    assert property (@(posedge clk) disable iff (rst)
        vblank_start |=> (scan_base == $past(slot_base[active_nxt])))
        else $error("load_match_chk");

    // R4
    // a request alone does not move the visible slot
    assert property (@(posedge clk) disable iff (rst)
        (flip_req && !vblank_start) |=> (pending && $stable(scan_slot)))
        else $error("req_wait_chk");
endmodule

// File: tb/test_flip_scanout_top.sv
module test_flip_scanout_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        vblank_start = 1'b0;
    logic [63:0] scan_base;
    logic        scan_slot;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [31:0] A0L = 32'h1000_0000, A0H = 32'h0000_00A0;
    localparam logic [31:0] A1L = 32'h2000_4000, A1H = 32'h0000_00B1;

    always #5 clk = ~clk;

    flip_scanout_top i_flip_scanout_top (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .vblank_start(vblank_start), .scan_base(scan_base), .scan_slot(scan_slot)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; returns at the following falling edge
    task automatic cyc(input logic we, input logic [2:0] idx, input logic [31:0] d, input logic vb);
        @(negedge clk);
        reg_we = we; reg_idx = idx; reg_wdata = d; vblank_start = vb;
        @(negedge clk);
        reg_we = 1'b0; vblank_start = 1'b0;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        cyc(1'b1, idx, d, 1'b0);
    endtask

    task automatic strobe();
        cyc(1'b0, 3'd0, 32'd0, 1'b1);
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd0, d); check("R1 ctrl", 64'(d), 64'h0);
        rd(3'd1, d); check("R1 s0lo", 64'(d), 64'h0);
        rd(3'd4, d); check("R1 s1hi", 64'(d), 64'h0);
        check("R1 base", scan_base, 64'h0);
        check("R1 slot", 64'(scan_slot), 64'h0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(3'd1, A0L); wr(3'd2, A0H); wr(3'd3, A1L); wr(3'd4, A1H);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd1, d); check("R2 s0lo", 64'(d), 64'(A0L));
        rd(3'd2, d); check("R2 s0hi", 64'(d), 64'(A0H));
        rd(3'd3, d); check("R2 s1lo", 64'(d), 64'(A1L));
        rd(3'd4, d); check("R2 s1hi", 64'(d), 64'(A1H));
        rd(3'd5, d); check("R2 unused", 64'(d), 64'h0);
        check("R8 base before strobe", scan_base, 64'h0);
    endtask

    task automatic t_idle_strobe();
        logic [31:0] d;
        strobe();
        check("R7 base reload", scan_base, {A0H, A0L});
        check("R7 slot", 64'(scan_slot), 64'h0);
        rd(3'd0, d); check("R7 ctrl", 64'(d), 64'h0);
    endtask

    task automatic t_flip();
        logic [31:0] d;
        wr(3'd0, 32'h80);
        rd(3'd0, d); check("R3 R4 pending", 64'(d), 64'h80);
        check("R4 slot held", 64'(scan_slot), 64'h0);
        check("R4 base held", scan_base, {A0H, A0L});
        strobe();
        check("R5 slot", 64'(scan_slot), 64'h1);
        check("R5 base", scan_base, {A1H, A1L});
        rd(3'd0, d); check("R3 R5 ctrl", 64'(d), 64'h800);
    endtask

    task automatic t_merge_return();
        logic [31:0] d;
        wr(3'd0, 32'h80); wr(3'd0, 32'h80);
        strobe();
        check("R6 R10 slot", 64'(scan_slot), 64'h0);
        check("R10 base", scan_base, {A0H, A0L});
        rd(3'd0, d); check("R6 ctrl", 64'(d), 64'h0);
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        wr(3'd0, 32'h800);
        rd(3'd0, d); check("R9 bit11 write", 64'(d), 64'h0);
        strobe();
        check("R9 slot kept", 64'(scan_slot), 64'h0);
        wr(3'd0, 32'h80); wr(3'd0, 32'h0);
        rd(3'd0, d); check("R9 no cancel", 64'(d), 64'h80);
        strobe();
        check("R9 flip done", 64'(scan_slot), 64'h1);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        cyc(1'b1, 3'd0, 32'h80, 1'b1);
        check("R5 same-cycle slot", 64'(scan_slot), 64'h0);
        check("R5 same-cycle base", scan_base, {A0H, A0L});
        rd(3'd0, d); check("R5 same-cycle ctrl", 64'(d), 64'h0);
    endtask

    task automatic t_stable();
        wr(3'd1, 32'h3333_0000);
        check("R8 base held on edit", scan_base, {A0H, A0L});
        check("R8 slot held", 64'(scan_slot), 64'h0);
        strobe();
        check("R7 picks edit", scan_base, {A0H, 32'h3333_0000});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap();
        t_idle_strobe();
        t_flip();
        t_merge_return();
        t_ignore();
        t_same_cycle();
        t_stable();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule